// File: doc/BRIEF.md
# Endpoint Test Command Engine

This block is a small test function that a host controls through seven 32-bit registers. The host loads a source address, a destination address, a byte count and an expected checksum, and then writes a command word. The engine then reads a host buffer and checks its checksum, fills a host buffer with a known pattern, or copies one buffer to another. Every transfer goes through a word-wide master port to an external buffer memory, which returns read data one cycle after the request.

When the command finishes, the engine writes an outcome code into the status register, clears the command register and can signal the host. It signals either with a one-cycle MSI request that carries a 6-bit vector, or with a legacy interrupt level that stays high until the host writes the status register. A scratch register lets the host check its register path with a known pattern. Link handling, configuration space and address decoding sit outside the block.

Top module: `ep_test_engine`

## Requirements
- R1: Register index 0 is a scratch word that reads back exactly what was last written. Reads are registered: the value for `reg_addr` is on `reg_rdata` one cycle after `reg_rd` is high. Index 7 reads as zero. All registers reset to zero, and the interrupt outputs and `mem_req` reset low.
- R2: Register indices are: 0 scratch, 1 command, 2 status, 3 source address, 4 destination address, 5 byte count, 6 checksum.
- R3: A write to the command register is accepted only while the engine is idle. While it is busy, such a write is ignored and the command register keeps its value. The command register reads zero once the command completes.
- R4: Accepting a command clears status to zero. At completion, status is set to the outcome. Status bits: 0 read ok, 1 read fail, 2 write ok, 3 write fail, 4 copy ok, 5 copy fail, 6 interrupt raised, 7 bad source, 8 bad destination.
- R5: Command bit 8 selects read. The engine reads byte-count/4 words from the source address and XORs them together. It reports read ok if the result equals the checksum register and read fail otherwise. The checksum register is left unchanged.
- R6: Command bit 9 selects write. The engine writes word i of the destination buffer with 0xA5A50000+i and stores the XOR of the written words into the checksum register.
- R7: Command bit 10 selects copy. The engine moves byte-count/4 words from the source buffer to the destination buffer and stores the XOR of the moved words into the checksum register.
- R8: An operand is bad if the byte count is zero or not a multiple of 4, if its address is not word aligned, or if [address, address+count) leaves the window 0x100..0x2FF. A bad operand sets its bad bit and the fail bit of the operation, and the engine makes no memory access.
- R9: If several transfer bits are set, the lowest-numbered one is carried out. A command with no transfer bit performs no memory access and only raises the selected interrupt.
- R10: At completion, command bit 1 raises `msi_req` for exactly one cycle, with `msi_vec` equal to command bits 7:2. Otherwise command bit 0 raises `irq_legacy`, which stays high until the status register is written. If both bits are set, only MSI is raised. Raising either interrupt sets status bit 6.
- R11: Count the edge that accepts the command as edge 0, and let n be the number of words. Status, the command clear and the interrupt all appear after edge 2+2n for a read, 2+n for a write, 2+3n for a copy, and 2 for a command with a bad operand or no transfer bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Buffer memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | MEM_AW | Byte address of the word accessed |
| mem_wdata | output | 32 | Buffer write data |
| mem_rdata | input | 32 | Buffer read data, valid one cycle after a read request |
| irq_legacy | output | 1 | Level interrupt, held until status is written |
| msi_req | output | 1 | One-cycle MSI request |
| msi_vec | output | 6 | MSI vector number |

## Verification
Each command row in the bench carries its own due cycle, taken from R11. For example, a 4-word read is due at edge 10, and a bad operand is due at edge 2. The bench counts exactly that many edges after the accepting write and samples the interrupt outputs at the negative edge. It then checks that `msi_req` has dropped one cycle later. Register values are read back through the one-cycle read port, and buffer contents are compared after the due edge. The number of memory accesses is compared against n, 2n or zero per command, so an early finish, a late finish or a stray access each shows up.

// File: rtl/eptest_pkg.sv
package eptest_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR, OP_CP} op_e;

  localparam logic [2:0] RI_MAGIC = 3'd0;
  localparam logic [2:0] RI_CMD   = 3'd1;
  localparam logic [2:0] RI_STAT  = 3'd2;
  localparam logic [2:0] RI_SRC   = 3'd3;
  localparam logic [2:0] RI_DST   = 3'd4;
  localparam logic [2:0] RI_SIZE  = 3'd5;
  localparam logic [2:0] RI_CHK   = 3'd6;

  localparam int CB_LEG    = 0;
  localparam int CB_MSI    = 1;
  localparam int CB_VEC_LO = 2;
  localparam int CB_RD     = 8;
  localparam int CB_WR     = 9;
  localparam int CB_CP     = 10;
  localparam int VW        = 6;

  localparam int SB_RD_OK   = 0;
  localparam int SB_RD_BAD  = 1;
  localparam int SB_WR_OK   = 2;
  localparam int SB_WR_BAD  = 3;
  localparam int SB_CP_OK   = 4;
  localparam int SB_CP_BAD  = 5;
  localparam int SB_IRQ     = 6;
  localparam int SB_SRC_INV = 7;
  localparam int SB_DST_INV = 8;
  localparam int STW        = 9;
endpackage

// File: rtl/eptest_cmd_decode.sv
module eptest_cmd_decode
  import eptest_pkg::*;
(
  input  logic [CB_CP:0]  cmd,
  output op_e             op,
  output logic            want_msi,
  output logic            want_leg,
  output logic [VW-1:0]   vec
);
  always_comb begin
    // lowest-numbered transfer bit wins
    if (cmd[CB_RD])      op = OP_RD;
    else if (cmd[CB_WR]) op = OP_WR;
    else if (cmd[CB_CP]) op = OP_CP;
    else                 op = OP_NONE;
    want_msi = cmd[CB_MSI];
    want_leg = cmd[CB_LEG] & ~cmd[CB_MSI];
    vec      = cmd[CB_VEC_LO +: VW];
  end
endmodule

// File: rtl/eptest_range_chk.sv
module eptest_range_chk #(
  parameter logic [31:0] WIN_BASE  = 32'h0000_0100,
  parameter logic [31:0] WIN_BYTES = 32'h0000_0200
) (
  input  logic [31:0] addr,
  input  logic [31:0] size,
  output logic        ok
);
  localparam logic [33:0] WIN_END = {2'b00, WIN_BASE} + {2'b00, WIN_BYTES};

  logic [33:0] span_end;

  always_comb begin
    span_end = {2'b00, addr} + {2'b00, size};
    ok = (size != 32'd0) && (size[1:0] == 2'b00) && (addr[1:0] == 2'b00) &&
         (addr >= WIN_BASE) && (span_end <= WIN_END);
  end
endmodule

// File: rtl/eptest_xfer_engine.sv
module eptest_xfer_engine
  import eptest_pkg::*;
#(
  parameter int          MEM_AW    = 12,
  parameter logic [31:0] WIN_BASE  = 32'h0000_0100,
  parameter logic [31:0] WIN_BYTES = 32'h0000_0200,
  parameter logic [31:0] PAT_SEED  = 32'hA5A5_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  op_e               op_in,
  input  logic [31:0]       src_in,
  input  logic [31:0]       dst_in,
  input  logic [31:0]       size_in,
  input  logic [31:0]       chk_in,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [STW-1:0]    status,
  output logic [31:0]       acc_out,
  output logic              acc_store,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata
);
  localparam int IW = MEM_AW - 2;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_RD, S_RDW, S_WR, S_DONE} st_e;

  st_e         state;
  op_e         op_q;
  logic [31:0] src_q, dst_q, size_q, chk_q, acc, hold;
  logic [IW-1:0] idx, last_idx;
  logic        src_ok, dst_ok, rd_bad, wr_bad, last, fail;

  eptest_range_chk #(.WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_src_chk (
    .addr(src_q), .size(size_q), .ok(src_ok));
  eptest_range_chk #(.WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_dst_chk (
    .addr(dst_q), .size(size_q), .ok(dst_ok));

  always_comb begin
    last_idx  = size_q[MEM_AW-1:2] - IW'(1);
    last      = (idx == last_idx);
    rd_bad    = ((op_q == OP_RD) || (op_q == OP_CP)) && !src_ok;
    wr_bad    = ((op_q == OP_WR) || (op_q == OP_CP)) && !dst_ok;
    fail      = rd_bad || wr_bad || ((op_q == OP_RD) && (acc != chk_q));
    mem_req   = (state == S_RD) || (state == S_WR);
    mem_we    = (state == S_WR);
    mem_addr  = ((state == S_WR) ? dst_q[MEM_AW-1:0] : src_q[MEM_AW-1:0]) + {idx, 2'b00};
    mem_wdata = (op_q == OP_CP) ? hold : (PAT_SEED + 32'(idx));
    busy      = (state != S_IDLE);
    done      = (state == S_DONE);
    acc_out   = acc;
    acc_store = done && ((op_q == OP_WR) || (op_q == OP_CP)) && !rd_bad && !wr_bad;
    status    = '0;
    case (op_q)
      OP_RD: begin status[SB_RD_OK] = !fail; status[SB_RD_BAD] = fail; end
      OP_WR: begin status[SB_WR_OK] = !fail; status[SB_WR_BAD] = fail; end
      OP_CP: begin status[SB_CP_OK] = !fail; status[SB_CP_BAD] = fail; end
      default: ;
    endcase
    status[SB_SRC_INV] = rd_bad;
    status[SB_DST_INV] = wr_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      op_q   <= OP_NONE;
      src_q  <= '0;
      dst_q  <= '0;
      size_q <= '0;
      chk_q  <= '0;
      acc    <= '0;
      hold   <= '0;
      idx    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          op_q   <= op_in;
          src_q  <= src_in;
          dst_q  <= dst_in;
          size_q <= size_in;
          chk_q  <= chk_in;
          acc    <= '0;
          idx    <= '0;
          state  <= S_CHECK;
        end
        S_CHECK: begin
          if (op_q == OP_NONE || rd_bad || wr_bad) state <= S_DONE;
          else if (op_q == OP_WR)                  state <= S_WR;
          else                                     state <= S_RD;
        end
        S_RD: state <= S_RDW;
        S_RDW: begin
          acc  <= acc ^ mem_rdata;
          hold <= mem_rdata;
          if (op_q == OP_CP) state <= S_WR;
          else begin
            idx   <= idx + IW'(1);
            state <= last ? S_DONE : S_RD;
          end
        end
        S_WR: begin
          if (op_q == OP_WR) acc <= acc ^ mem_wdata;
          idx <= idx + IW'(1);
          if (last)                 state <= S_DONE;
          else if (op_q == OP_CP)   state <= S_RD;
          else                      state <= S_WR;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ep_test_engine.sv
module ep_test_engine
  import eptest_pkg::*;
#(
  parameter int          MEM_AW    = 12,
  parameter logic [31:0] WIN_BASE  = 32'h0000_0100,
  parameter logic [31:0] WIN_BYTES = 32'h0000_0200,
  parameter logic [31:0] PAT_SEED  = 32'hA5A5_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              irq_legacy,
  output logic              msi_req,
  output logic [5:0]        msi_vec
);
  logic [31:0]    magic_q, cmd_q, src_q, dst_q, size_q, chk_q;
  logic [STW-1:0] status_q;
  logic           busy, done, start, acc_store;
  logic [STW-1:0] eng_status;
  logic [31:0]    acc_out;
  logic [CB_CP:0] dec_in;
  op_e            dec_op;
  logic           want_msi, want_leg;
  logic [VW-1:0]  dec_vec;

  assign start  = reg_wr && (reg_addr == RI_CMD) && !busy;
  // idle: decode the incoming word; busy: decode the held command
  assign dec_in = busy ? cmd_q[CB_CP:0] : reg_wdata[CB_CP:0];

  eptest_cmd_decode u_dec (
    .cmd(dec_in), .op(dec_op), .want_msi(want_msi), .want_leg(want_leg), .vec(dec_vec));

  eptest_xfer_engine #(
    .MEM_AW(MEM_AW), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES), .PAT_SEED(PAT_SEED)
  ) u_eng (
    .clk(clk), .rst(rst), .start(start), .op_in(dec_op),
    .src_in(src_q), .dst_in(dst_q), .size_in(size_q), .chk_in(chk_q),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .status(eng_status),
    .acc_out(acc_out), .acc_store(acc_store),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      magic_q <= '0; cmd_q <= '0; src_q <= '0; dst_q <= '0;
      size_q <= '0; chk_q <= '0; status_q <= '0;
      irq_legacy <= 1'b0; msi_req <= 1'b0; msi_vec <= '0; reg_rdata <= '0;
    end else begin
      msi_req <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          RI_MAGIC: magic_q <= reg_wdata;
          RI_CMD:   if (!busy) cmd_q <= reg_wdata;
          RI_STAT:  irq_legacy <= 1'b0;
          RI_SRC:   src_q <= reg_wdata;
          RI_DST:   dst_q <= reg_wdata;
          RI_SIZE:  size_q <= reg_wdata;
          RI_CHK:   chk_q <= reg_wdata;
          default: ;
        endcase
      end
      if (start) status_q <= '0;
      if (done) begin
        status_q <= eng_status | (STW'(want_msi | want_leg) << SB_IRQ);
        cmd_q    <= '0;
        if (acc_store) chk_q <= acc_out;
        if (want_msi) begin
          msi_req <= 1'b1;
          msi_vec <= dec_vec;
        end else if (want_leg) begin
          irq_legacy <= 1'b1;
        end
      end
      if (reg_rd) begin
        case (reg_addr)
          RI_MAGIC: reg_rdata <= magic_q;
          RI_CMD:   reg_rdata <= cmd_q;
          RI_STAT:  reg_rdata <= 32'(status_q);
          RI_SRC:   reg_rdata <= src_q;
          RI_DST:   reg_rdata <= dst_q;
          RI_SIZE:  reg_rdata <= size_q;
          RI_CHK:   reg_rdata <= chk_q;
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ep_test_engine_chk.sv
module ep_test_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        start,
  input logic        done,
  input logic        cmd_wr,
  input logic        stat_wr,
  input logic        mem_req,
  input logic        msi_req,
  input logic        irq_legacy,
  input logic [8:0]  status_q,
  input logic [31:0] cmd_q
);
  p_cmd_clear_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> (cmd_q == 32'd0));

  p_busy_ignore_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && cmd_wr) |=> $stable(cmd_q));

  p_status_clear_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> (status_q == 9'd0));

  p_no_mem_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  p_msi_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    msi_req |=> !msi_req);

  p_legacy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_legacy && !stat_wr) |=> irq_legacy);

  p_irq_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (msi_req || $rose(irq_legacy)) |-> status_q[6]);
endmodule

bind ep_test_engine ep_test_engine_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .start(start), .done(done),
  .cmd_wr(reg_wr && (reg_addr == 3'd1)), .stat_wr(reg_wr && (reg_addr == 3'd2)),
  .mem_req(mem_req), .msi_req(msi_req), .irq_legacy(irq_legacy),
  .status_q(status_q), .cmd_q(cmd_q));

// File: tb/ep_test_engine_tb_top.sv
module ep_test_engine_tb_top;
  localparam int MEM_AW = 12;
  localparam logic [31:0] SEED = 32'hA5A5_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic mem_req, mem_we, irq_legacy, msi_req;
  logic [MEM_AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [5:0] msi_vec;

  always #5 clk = ~clk;

  ep_test_engine #(.MEM_AW(MEM_AW)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq_legacy(irq_legacy), .msi_req(msi_req), .msi_vec(msi_vec));

  // buffer memory model, one-cycle read latency
  logic [31:0] mem [0:1023];
  int unsigned acc_cnt = 0;
  logic [31:0] rdq = 32'd0;
  assign mem_rdata = rdq;

  function automatic logic [31:0] image(input int unsigned i);
    return (i * 32'h0101_0101) ^ 32'h5A00_0000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 1024; i++) mem[i] <= image(i);
    end else if (mem_req) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr[MEM_AW-1:2]] <= mem_wdata;
      else        rdq <= mem[mem_addr[MEM_AW-1:2]];
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  function automatic logic [31:0] read_ref(input logic [31:0] src, input logic [31:0] size);
    logic [31:0] x = 32'd0;
    for (int i = 0; i < int'(size / 4); i++) x ^= image(src / 4 + i);
    return x;
  endfunction

  typedef struct packed {
    logic [31:0] cmd; logic [31:0] src; logic [31:0] dst; logic [31:0] size;
    logic good; logic [8:0] st; logic [7:0] lat;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{32'h116, 32'h100, 32'h000, 32'd16, 1'b1, 9'h041, 8'd10}, // read ok, MSI 5
    '{32'h101, 32'h108, 32'h000, 32'd8,  1'b0, 9'h042, 8'd6},  // read fail, legacy
    '{32'h200, 32'h000, 32'h200, 32'd12, 1'b0, 9'h004, 8'd5},  // write
    '{32'h4FE, 32'h110, 32'h280, 32'd8,  1'b0, 9'h050, 8'd8},  // copy, MSI 63
    '{32'h100, 32'h2F8, 32'h000, 32'd16, 1'b1, 9'h082, 8'd2},  // src leaves window
    '{32'h200, 32'h000, 32'h200, 32'd0,  1'b0, 9'h108, 8'd2},  // zero size
    '{32'h400, 32'h100, 32'h202, 32'd4,  1'b0, 9'h120, 8'd2},  // unaligned dst
    '{32'h500, 32'h100, 32'h000, 32'd4,  1'b1, 9'h001, 8'd4},  // read beats copy
    '{32'h227, 32'h000, 32'h2C0, 32'd4,  1'b0, 9'h044, 8'd3},  // MSI beats legacy
    '{32'h001, 32'h000, 32'h000, 32'd0,  1'b0, 9'h040, 8'd2}   // interrupt only
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ref_x, exp_chk;
    int unsigned c0, n, exp_acc;
    int op;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 reset irq_legacy", 32'(irq_legacy), 0);
    check("R1 reset msi_req", 32'(msi_req), 0);
    check("R1 reset mem_req", 32'(mem_req), 0);
    for (int a = 0; a < 7; a++) begin
      reg_read(3'(a), d);
      check("R1 R2 reset register", d, 0);
    end
    // R1 R2 scratch and unused index
    reg_write(3'd0, 32'hC0FF_EE11);
    reg_read(3'd0, d);  check("R1 scratch readback", d, 32'hC0FF_EE11);
    reg_write(3'd3, 32'h0000_0144);
    reg_read(3'd3, d);  check("R2 source register index 3", d, 32'h144);
    reg_read(3'd7, d);  check("R1 index 7 reads zero", d, 0);

    foreach (VECS[k]) begin
      vec_t v = VECS[k];
      op = v.cmd[8] ? 1 : v.cmd[9] ? 2 : v.cmd[10] ? 3 : 0;   // R9 priority
      n = v.size / 4;
      ref_x = read_ref(v.src, v.size);
      reg_write(3'd2, 32'd0);
      reg_write(3'd3, v.src);
      reg_write(3'd4, v.dst);
      reg_write(3'd5, v.size);
      reg_write(3'd6, v.good ? ref_x : ~ref_x);
      c0 = acc_cnt;
      reg_write(3'd1, v.cmd);
      repeat (int'(v.lat)) @(negedge clk);
      // R11 due cycle, R10 interrupt selection
      check("R10 R11 msi_req at due edge", 32'(msi_req), 32'(v.cmd[1]));
      if (v.cmd[1]) check("R10 msi_vec", 32'(msi_vec), 32'(v.cmd[7:2]));
      check("R10 R11 irq_legacy at due edge", 32'(irq_legacy), 32'(v.cmd[0] & ~v.cmd[1]));
      @(negedge clk);
      check("R10 msi_req one cycle", 32'(msi_req), 0);
      reg_read(3'd2, d);
      check("R4 R5 R8 status", d, 32'(v.st));
      reg_read(3'd1, d);
      check("R3 command cleared", d, 0);
      exp_acc = (v.st[7] || v.st[8]) ? 0 : (op == 1 || op == 2) ? n : (op == 3) ? 2 * n : 0;
      check("R8 R9 memory access count", acc_cnt - c0, exp_acc);
      reg_read(3'd6, d);
      if (op == 2 && v.st[2]) begin
        exp_chk = 32'd0;
        for (int i = 0; i < int'(n); i++) begin
          exp_chk ^= SEED + 32'(i);
          check("R6 write pattern", mem[v.dst / 4 + i], SEED + 32'(i));
        end
        check("R6 write checksum", d, exp_chk);
      end else if (op == 3 && v.st[4]) begin
        for (int i = 0; i < int'(n); i++)
          check("R7 copy data", mem[v.dst / 4 + i], image(v.src / 4 + i));
        check("R7 copy checksum", d, ref_x);
      end else begin
        check("R5 R8 checksum untouched", d, v.good ? ref_x : ~ref_x);
      end
    end

    // R3 R4 busy: status cleared at start, command write ignored
    reg_write(3'd3, 32'h100);
    reg_write(3'd4, 32'h240);
    reg_write(3'd5, 32'd32);
    c0 = acc_cnt;
    reg_write(3'd1, 32'h400);
    reg_read(3'd2, d);  check("R4 status cleared at start", d, 0);
    reg_read(3'd1, d);  check("R3 command held while busy", d, 32'h400);
    reg_write(3'd1, 32'h100);
    reg_read(3'd1, d);  check("R3 busy write ignored", d, 32'h400);
    repeat (30) @(negedge clk);
    reg_read(3'd2, d);  check("R3 R7 copy after ignored write", d, 32'h010);
    check("R3 R7 copy access count", acc_cnt - c0, 16);
    for (int i = 0; i < 8; i++)
      check("R7 long copy data", mem[32'h240 / 4 + i], image(32'h100 / 4 + i));

    // R10 legacy held until status written
    reg_write(3'd1, 32'h001);
    repeat (2) @(negedge clk);
    check("R10 legacy raised", 32'(irq_legacy), 1);
    repeat (5) @(negedge clk);
    check("R10 legacy held", 32'(irq_legacy), 1);
    reg_read(3'd2, d);
    check("R10 legacy survives status read", 32'(irq_legacy), 1);
    reg_write(3'd2, 32'd0);
    check("R10 legacy cleared by status write", 32'(irq_legacy), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule